// File: doc/BRIEF.md
# Copyback Data Cache Line Controller

This block keeps the tag and line-state bookkeeping for a small four-way set-associative data cache. Each line is Invalid, Valid (clean) or Modified. The block takes one CPU read or write at a time and decides hit or miss from the tag and state arrays. It moves line states and picks a victim way when a line must be allocated. It talks to memory over a single request/acknowledge port that carries line addresses only. The data path is not part of this block.

Each access is handled as copyback or write-through. A matching region gives the mode; when no region matches, a default mode applies. On a miss that allocates, a dirty victim is parked in a one-line holding buffer. The new line is fetched first and the parked line is written back after it. Two maintenance commands are supported: invalidate-all, which discards every line, and push-line, which writes back one selected line and then either invalidates it or keeps it clean.

Top module: `dcache_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, every replacement pointer is 0, `req_ready` is 1, and `mem_req` and `acc_valid` are 0.
- R2: The mode of an access is copyback (1) or write-through (0). It is `rgn_copyback` when `rgn_match` is 1 and `dflt_copyback` otherwise.
- R3: An accepted request produces `acc_valid`=1 on the following cycle. `acc_hit` is 1 exactly when a valid line of the addressed set holds the address tag. `acc_valid` is 0 in every cycle that does not follow an acceptance.
- R4: A read miss in either mode, and a write miss in copyback mode, allocate a way and issue one line fill (`mem_we`=0, address = tag and set). The line becomes Valid after a read fill and Modified after a write fill.
- R5: A copyback write hit marks the line Modified and issues no memory traffic. A read hit changes no state and issues no memory traffic.
- R6: When the set has an Invalid way, the lowest-numbered Invalid way is allocated and the replacement pointer of the set does not move.
- R7: When all four ways are valid, the way named by the set's 2-bit pointer is replaced. The pointer then advances by one modulo 4, and this replacement is the only event that moves it.
- R8: A Modified victim is parked and its writeback (`mem_we`=1, the victim's line address) is issued only after the new line's fill completes. A clean victim is dropped with no writeback.
- R9: A write-through write, hit or miss, issues one memory write of its line address. It never sets Modified, and a write-through write miss allocates nothing.
- R10: Invalidate-all makes every line Invalid in one cycle and issues no memory traffic.
- R11: A push with `push_keep`=0 writes back a Modified line and then invalidates it. It invalidates a Valid line with no traffic and leaves an Invalid line untouched.
- R12: A push with `push_keep`=1 writes back a Modified line and leaves it Valid and clean. It does nothing to a Valid line.
- R13: `req_ready` is 1 only when no fill, writeback, write-through write or push is pending. Requests and commands are taken only while it is 1, and invalidate-all takes priority over a push, which takes priority over a request. `mem_req`, `mem_we` and `mem_addr` hold until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| rgn_match | input | 1 | A region attribute applies to this access |
| rgn_copyback | input | 1 | Region mode, 1 = copyback |
| dflt_copyback | input | 1 | Default mode when no region matches |
| req_ready | output | 1 | Controller idle; request or command is taken |
| acc_valid | output | 1 | Lookup result valid (cycle after acceptance) |
| acc_hit | output | 1 | Lookup hit |
| inv_all | input | 1 | Invalidate every line |
| push_valid | input | 1 | Push-line command |
| push_set | input | SET_W | Set of the pushed line |
| push_way | input | WAY_W | Way of the pushed line |
| push_keep | input | 1 | 1 = keep pushed line valid and clean |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write to memory, 0 = line fill |
| mem_addr | output | LINE_W | Line address (tag and set) |
| mem_ack | input | 1 | Memory transfer complete |

## Verification
The hardest situation to reach is a replacement in a full set whose victim is dirty, while the pointer sits at a known value. Reaching it also shows that the fill goes out before the parked writeback. The stimulus fills an empty set with four copyback write misses, so every way is Modified and the pointer is still 0. One line is then pushed clean, and further read misses are marched through the set. The memory log is compared, transaction by transaction, with the pointer sequence 0,1,2,3,0. Write-through writes and region-versus-default mode selection get their own sets, so their traffic cannot be confused with replacement traffic.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_WB,
    ST_WT,
    ST_PUSH
  } dcl_state_e;

  // Region attribute wins; the default applies only when no region matches.
  function automatic logic pick_mode(input logic rgn_hit,
                                     input logic rgn_cb,
                                     input logic dflt_cb);
    return rgn_hit ? rgn_cb : dflt_cb;
  endfunction

endpackage

// File: rtl/dcl_tag_store.sv
module dcl_tag_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 10,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_all,
  input  logic                  wr_en,
  input  logic [SET_W-1:0]      wr_set,
  input  logic [WAY_W-1:0]      wr_way,
  input  logic [TAG_W-1:0]      wr_tag,
  input  logic                  wr_v,
  input  logic                  wr_m,
  input  logic [SET_W-1:0]      rd_set,
  output logic [WAYS*TAG_W-1:0] rd_tag,
  output logic [WAYS-1:0]       rd_v,
  output logic [WAYS-1:0]       rd_m
);

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  v_q   [SETS];
  logic [WAYS-1:0]  m_q   [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        v_q[s] <= '0;
        m_q[s] <= '0;
      end
    end else if (clr_all) begin
      for (int s = 0; s < SETS; s++) begin
        v_q[s] <= '0;
        m_q[s] <= '0;
      end
    end else if (wr_en) begin
      v_q[wr_set][wr_way] <= wr_v;
      m_q[wr_set][wr_way] <= wr_m;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way] <= wr_tag;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_tag[w*TAG_W +: TAG_W] = tag_q[rd_set][w];
  end
  assign rd_v = v_q[rd_set];
  assign rd_m = m_q[rd_set];

endmodule

// File: rtl/dcl_hit_detect.sv
module dcl_hit_detect #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 10,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS*TAG_W-1:0] set_tags,
  input  logic [WAYS-1:0]       set_v,
  input  logic [TAG_W-1:0]      tag_i,
  output logic                  hit_o,
  output logic [WAY_W-1:0]      hit_way_o
);

  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = set_v[w] && (set_tags[w*TAG_W +: TAG_W] == tag_i);
  end

  assign hit_o = |match;

  always_comb begin
    hit_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way_o = WAY_W'(w);
    end
  end

endmodule

// File: rtl/dcl_victim_pick.sv
module dcl_victim_pick #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_i,
  input  logic [WAYS-1:0]  v_i,
  input  logic             adv_i,
  output logic [WAY_W-1:0] way_o,
  output logic             full_o
);

  logic [WAY_W-1:0] rr_q [SETS];
  logic [WAY_W-1:0] free_way;

  // Lowest-numbered invalid way wins.
  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!v_i[w]) free_way = WAY_W'(w);
    end
  end

  assign full_o = &v_i;
  assign way_o  = full_o ? rr_q[set_i] : free_way;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (adv_i) begin
      rr_q[set_i] <= rr_q[set_i] + WAY_W'(1);
    end
  end

endmodule

// File: rtl/dcache_line_ctrl.sv
module dcache_line_ctrl
  import dcl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              rgn_match,
  input  logic              rgn_copyback,
  input  logic              dflt_copyback,
  output logic              req_ready,
  output logic              acc_valid,
  output logic              acc_hit,
  input  logic              inv_all,
  input  logic              push_valid,
  input  logic [SET_W-1:0]  push_set,
  input  logic [WAY_W-1:0]  push_way,
  input  logic              push_keep,
  output logic              mem_req,
  output logic              mem_we,
  output logic [LINE_W-1:0] mem_addr,
  input  logic              mem_ack
);

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  dcl_state_e st_q;

  logic [SET_W-1:0]  f_set_q, p_set_q;
  logic [WAY_W-1:0]  f_way_q, p_way_q;
  logic [TAG_W-1:0]  f_tag_q, p_tag_q;
  logic              f_write_q, p_keep_q;
  logic              buf_valid_q;
  logic [LINE_W-1:0] buf_line_q, wt_line_q;
  logic              acc_valid_q, acc_hit_q;

  // Named internal events (used by the bound checker too).
  logic idle, inv_ev, push_ev, accept_ev, alloc_ev, wt_ev, cbw_hit_ev;
  logic fill_done_ev, wb_pending;

  logic [SET_W-1:0]      rd_set;
  logic [WAYS*TAG_W-1:0] rd_tag;
  logic [WAYS-1:0]       rd_v, rd_m;
  logic                  hit;
  logic [WAY_W-1:0]      hit_way, vic_way;
  logic                  vic_full, vic_v, vic_m;
  logic [TAG_W-1:0]      vic_tag, p_tag, req_tag;
  logic [SET_W-1:0]      req_set;
  logic                  p_v, p_m, cb;

  logic             wr_en, wr_v, wr_m, adv;
  logic [SET_W-1:0] wr_set;
  logic [WAY_W-1:0] wr_way;
  logic [TAG_W-1:0] wr_tag;

  assign req_tag = tag_of(req_addr);
  assign req_set = set_of(req_addr);
  assign cb      = pick_mode(rgn_match, rgn_copyback, dflt_copyback);

  assign idle      = (st_q == ST_IDLE);
  assign inv_ev    = idle && inv_all;
  assign push_ev   = idle && !inv_all && push_valid;
  assign accept_ev = idle && !inv_all && !push_valid && req_valid;

  assign rd_set = push_valid ? push_set : req_set;

  dcl_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_all(inv_ev),
    .wr_en  (wr_en),
    .wr_set (wr_set),
    .wr_way (wr_way),
    .wr_tag (wr_tag),
    .wr_v   (wr_v),
    .wr_m   (wr_m),
    .rd_set (rd_set),
    .rd_tag (rd_tag),
    .rd_v   (rd_v),
    .rd_m   (rd_m)
  );

  dcl_hit_detect #(.WAYS(WAYS), .TAG_W(TAG_W)) u_hit (
    .set_tags (rd_tag),
    .set_v    (rd_v),
    .tag_i    (req_tag),
    .hit_o    (hit),
    .hit_way_o(hit_way)
  );

  dcl_victim_pick #(.SETS(SETS), .WAYS(WAYS)) u_vic (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (req_set),
    .v_i   (rd_v),
    .adv_i (adv),
    .way_o (vic_way),
    .full_o(vic_full)
  );

  assign vic_v   = rd_v[vic_way];
  assign vic_m   = rd_m[vic_way];
  assign vic_tag = rd_tag[vic_way*TAG_W +: TAG_W];
  assign p_v     = rd_v[push_way];
  assign p_m     = rd_m[push_way];
  assign p_tag   = rd_tag[push_way*TAG_W +: TAG_W];

  assign cbw_hit_ev   = accept_ev && hit && req_write && cb;
  assign wt_ev        = accept_ev && req_write && !cb;
  assign alloc_ev     = accept_ev && !hit && (!req_write || cb);
  assign fill_done_ev = (st_q == ST_FILL) && mem_ack;
  assign wb_pending   = buf_valid_q;

  // Single write port into the tag/state arrays.
  always_comb begin
    wr_en  = 1'b0;
    wr_set = req_set;
    wr_way = '0;
    wr_tag = req_tag;
    wr_v   = 1'b0;
    wr_m   = 1'b0;
    adv    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (push_ev) begin
          if (p_v && !p_m && !push_keep) begin
            wr_en  = 1'b1;
            wr_set = push_set;
            wr_way = push_way;
            wr_tag = p_tag;
          end
        end else if (cbw_hit_ev) begin
          wr_en  = 1'b1;
          wr_way = hit_way;
          wr_v   = 1'b1;
          wr_m   = 1'b1;
        end else if (alloc_ev) begin
          wr_en  = 1'b1;
          wr_way = vic_way;
          adv    = vic_full;
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          wr_en  = 1'b1;
          wr_set = f_set_q;
          wr_way = f_way_q;
          wr_tag = f_tag_q;
          wr_v   = 1'b1;
          wr_m   = f_write_q;
        end
      end
      ST_PUSH: begin
        if (mem_ack) begin
          wr_en  = 1'b1;
          wr_set = p_set_q;
          wr_way = p_way_q;
          wr_tag = p_tag_q;
          wr_v   = p_keep_q;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      buf_valid_q <= 1'b0;
      buf_line_q  <= '0;
      wt_line_q   <= '0;
      f_set_q     <= '0;
      f_way_q     <= '0;
      f_tag_q     <= '0;
      f_write_q   <= 1'b0;
      p_set_q     <= '0;
      p_way_q     <= '0;
      p_tag_q     <= '0;
      p_keep_q    <= 1'b0;
      acc_valid_q <= 1'b0;
      acc_hit_q   <= 1'b0;
    end else begin
      acc_valid_q <= accept_ev;
      acc_hit_q   <= accept_ev && hit;
      unique case (st_q)
        ST_IDLE: begin
          if (push_ev) begin
            if (p_v && p_m) begin
              st_q     <= ST_PUSH;
              p_set_q  <= push_set;
              p_way_q  <= push_way;
              p_tag_q  <= p_tag;
              p_keep_q <= push_keep;
            end
          end else if (wt_ev) begin
            st_q      <= ST_WT;
            wt_line_q <= line_of(req_addr);
          end else if (alloc_ev) begin
            st_q      <= ST_FILL;
            f_set_q   <= req_set;
            f_way_q   <= vic_way;
            f_tag_q   <= req_tag;
            f_write_q <= req_write;
            if (vic_v && vic_m) begin
              buf_valid_q <= 1'b1;
              buf_line_q  <= {vic_tag, req_set};
            end
          end
        end
        ST_FILL: if (mem_ack) st_q <= buf_valid_q ? ST_WB : ST_IDLE;
        ST_WB: begin
          if (mem_ack) begin
            buf_valid_q <= 1'b0;
            st_q        <= ST_IDLE;
          end
        end
        ST_WT:   if (mem_ack) st_q <= ST_IDLE;
        ST_PUSH: if (mem_ack) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = idle;
  assign acc_valid = acc_valid_q;
  assign acc_hit   = acc_hit_q;
  assign mem_req   = (st_q != ST_IDLE);
  assign mem_we    = (st_q != ST_FILL);

  always_comb begin
    unique case (st_q)
      ST_FILL: mem_addr = {f_tag_q, f_set_q};
      ST_WB:   mem_addr = buf_line_q;
      ST_WT:   mem_addr = wt_line_q;
      ST_PUSH: mem_addr = {p_tag_q, p_set_q};
      default: mem_addr = '0;
    endcase
  end

endmodule

// File: rtl/dcl_checker.sv
module dcl_checker #(
  parameter int LINE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              inv_all,
  input logic              acc_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic [LINE_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              accept_ev,
  input logic              fill_done_ev,
  input logic              wb_pending
);

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr)); // R13

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R13

  AST_ACC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> acc_valid); // R3

  AST_ACC_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_ev |=> !acc_valid); // R3

  AST_WB_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done_ev && wb_pending |=> mem_req && mem_we); // R8

  AST_INV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all && req_ready |=> !mem_req && req_ready); // R10

endmodule

bind dcache_line_ctrl dcl_checker #(.LINE_W(LINE_W)) u_dcl_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .inv_all     (inv_all),
  .acc_valid   (acc_valid),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_ack     (mem_ack),
  .accept_ev   (accept_ev),
  .fill_done_ev(fill_done_ev),
  .wb_pending  (wb_pending)
);

// File: tb/dcache_line_ctrl_tb.sv
module dcache_line_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic        rgn_match = 1'b0, rgn_copyback = 1'b0, dflt_copyback = 1'b0;
  logic        req_ready, acc_valid, acc_hit;
  logic        inv_all = 1'b0, push_valid = 1'b0, push_keep = 1'b0;
  logic [1:0]  push_set = '0, push_way = '0;
  logic        mem_req, mem_we;
  logic [11:0] mem_addr;
  logic        mem_ack = 1'b0;

  int total = 0;
  int bad = 0;
  int stall_bad = 0;

  logic        log_we   [256];
  logic [11:0] log_addr [256];
  int          log_n = 0;
  int          lat = 0;

  always #2 clk = ~clk;

  dcache_line_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .rgn_match(rgn_match), .rgn_copyback(rgn_copyback), .dflt_copyback(dflt_copyback),
    .req_ready(req_ready), .acc_valid(acc_valid), .acc_hit(acc_hit),
    .inv_all(inv_all), .push_valid(push_valid), .push_set(push_set),
    .push_way(push_way), .push_keep(push_keep),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack)
  );

  // Memory model: acknowledge after a short latency, log each transfer.
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      lat     <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (lat == 2) begin
        mem_ack         <= 1'b1;
        lat             <= 0;
        log_we[log_n]   <= mem_we;
        log_addr[log_n] <= mem_addr;
        log_n           <= log_n + 1;
      end else begin
        lat <= lat + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && mem_req && req_ready) stall_bad++;
  end

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_addr(input int tg, input int st);
    return {tg[9:0], st[1:0], 4'h0};
  endfunction

  function automatic int mk_line(input int tg, input int st);
    return {20'h0, tg[9:0], st[1:0]};
  endfunction

  task automatic chk_log(input string rq, input int idx, input int we, input int line);
    chk(rq, {19'h0, log_we[idx], log_addr[idx]}, (we << 12) | line);
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic access(input bit wr, input int tg, input int st,
                        input bit rm, input bit rc, input bit dc,
                        output bit hit, output bit busy);
    wait_ready();
    req_valid = 1'b1; req_write = wr; req_addr = mk_addr(tg, st);
    rgn_match = rm; rgn_copyback = rc; dflt_copyback = dc;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 acc_valid", int'(acc_valid), 1);
    hit  = acc_hit;
    busy = !req_ready;
    wait_ready();
  endtask

  task automatic cb_acc(input bit wr, input int tg, input int st, output bit hit);
    bit busy;
    access(wr, tg, st, 1'b1, 1'b1, 1'b0, hit, busy);
  endtask

  task automatic push(input int st, input int way, input bit keep);
    wait_ready();
    push_valid = 1'b1; push_set = st[1:0]; push_way = way[1:0]; push_keep = keep;
    @(negedge clk);
    push_valid = 1'b0;
    wait_ready();
  endtask

  task automatic t_reset();
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 mem_req", int'(mem_req), 0);
    chk("R1 acc_valid", int'(acc_valid), 0);
  endtask

  task automatic t_read_fill();
    bit h, busy;
    int n0 = log_n;
    access(1'b0, 'h11, 0, 1'b1, 1'b1, 1'b0, h, busy);
    chk("R4 read miss", int'(h), 0);
    chk("R13 stalled during fill", int'(busy), 1);
    chk("R4 one fill", log_n - n0, 1);
    chk_log("R4 fill addr", n0, 0, mk_line('h11, 0));
    cb_acc(1'b0, 'h11, 0, h);
    chk("R4 line valid after fill", int'(h), 1);
    chk("R5 read hit no traffic", log_n - n0, 1);
  endtask

  task automatic t_push_keep();
    bit h;
    int n0 = log_n;
    cb_acc(1'b1, 'h11, 0, h);
    chk("R5 write hit", int'(h), 1);
    chk("R5 write hit no traffic", log_n - n0, 0);
    push(0, 0, 1'b1);
    chk("R12 push keep writeback", log_n - n0, 1);
    chk_log("R12 push addr", n0, 1, mk_line('h11, 0));
    cb_acc(1'b0, 'h11, 0, h);
    chk("R12 line still valid", int'(h), 1);
    push(0, 0, 1'b1);
    chk("R12 clean push quiet", log_n - n0, 1);
  endtask

  task automatic t_push_inval();
    bit h;
    int n0 = log_n;
    cb_acc(1'b1, 'h11, 0, h);
    push(0, 0, 1'b0);
    chk("R11 dirty push writeback", log_n - n0, 1);
    chk_log("R11 push addr", n0, 1, mk_line('h11, 0));
    cb_acc(1'b0, 'h11, 0, h);
    chk("R11 line invalid after push", int'(h), 0);
    push(0, 0, 1'b0);
    chk("R11 clean push quiet", log_n - n0, 2);
    cb_acc(1'b0, 'h11, 0, h);
    chk("R11 clean line invalidated", int'(h), 0);
  endtask

  task automatic t_replace();
    bit h;
    int n0 = log_n;
    for (int t = 1; t <= 4; t++) begin
      cb_acc(1'b1, t, 1, h);
      chk("R4 write miss", int'(h), 0);
    end
    chk("R6 no writeback while free ways", log_n - n0, 4);
    for (int t = 1; t <= 4; t++) chk_log("R4 write miss fill", n0 + t - 1, 0, mk_line(t, 1));
    push(1, 2, 1'b1);
    chk_log("R6 tag 3 in way 2", n0 + 4, 1, mk_line(3, 1));
    n0 = log_n;
    cb_acc(1'b0, 5, 1, h);
    chk("R7 miss on full set", int'(h), 0);
    chk_log("R8 fill first", n0, 0, mk_line(5, 1));
    chk_log("R7 way0 victim written back", n0 + 1, 1, mk_line(1, 1));
    cb_acc(1'b0, 6, 1, h);
    chk_log("R8 fill first", n0 + 2, 0, mk_line(6, 1));
    chk_log("R7 way1 victim", n0 + 3, 1, mk_line(2, 1));
    cb_acc(1'b0, 7, 1, h);
    chk("R8 clean victim dropped", log_n - n0, 5);
    chk_log("R8 fill only", n0 + 4, 0, mk_line(7, 1));
    cb_acc(1'b0, 8, 1, h);
    chk_log("R7 way3 victim", n0 + 6, 1, mk_line(4, 1));
    cb_acc(1'b0, 9, 1, h);
    chk("R7 wrap to way0 clean", log_n - n0, 8);
    cb_acc(1'b0, 6, 1, h);
    chk("R7 way1 kept", int'(h), 1);
    cb_acc(1'b0, 5, 1, h);
    chk("R7 tag 5 replaced", int'(h), 0);
  endtask

  task automatic t_write_through();
    bit h, busy;
    int n0 = log_n;
    access(1'b1, 'h20, 2, 1'b1, 1'b0, 1'b1, h, busy);
    chk("R9 wt write miss", int'(h), 0);
    chk("R9 one write", log_n - n0, 1);
    chk_log("R9 write addr", n0, 1, mk_line('h20, 2));
    access(1'b0, 'h20, 2, 1'b1, 1'b0, 1'b1, h, busy);
    chk("R9 no allocation", int'(h), 0);
    chk_log("R4 wt read miss fills", n0 + 1, 0, mk_line('h20, 2));
    access(1'b1, 'h20, 2, 1'b1, 1'b0, 1'b1, h, busy);
    chk("R9 wt write hit", int'(h), 1);
    chk_log("R9 wt hit writes", n0 + 2, 1, mk_line('h20, 2));
    push(2, 0, 1'b1);
    chk("R9 M never set", log_n - n0, 3);
  endtask

  task automatic t_mode();
    bit h, busy;
    int n0 = log_n;
    access(1'b1, 'h30, 3, 1'b0, 1'b1, 1'b0, h, busy);
    chk_log("R2 default wt", n0, 1, mk_line('h30, 3));
    access(1'b1, 'h31, 3, 1'b1, 1'b1, 1'b0, h, busy);
    chk_log("R2 region cb overrides", n0 + 1, 0, mk_line('h31, 3));
    access(1'b1, 'h32, 3, 1'b0, 1'b0, 1'b1, h, busy);
    chk_log("R2 default cb", n0 + 2, 0, mk_line('h32, 3));
    chk("R2 traffic count", log_n - n0, 3);
  endtask

  task automatic t_inv_all();
    bit h;
    int n0;
    cb_acc(1'b1, 8, 1, h);
    chk("R5 write hit", int'(h), 1);
    n0 = log_n;
    wait_ready();
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    chk("R10 ready after inv", int'(req_ready), 1);
    repeat (4) @(negedge clk);
    chk("R10 no traffic", log_n - n0, 0);
    cb_acc(1'b0, 8, 1, h);
    chk("R10 line invalid", int'(h), 0);
    chk("R10 no writeback of dropped line", log_n - n0, 1);
    cb_acc(1'b0, 'h32, 3, h);
    chk("R10 other set invalid", int'(h), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_fill();
    t_push_keep();
    t_push_inval();
    t_replace();
    t_write_through();
    t_mode();
    t_inv_all();
    chk("R13 no ready while busy", stall_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule